// File: doc/BRIEF.md
# Memory and Bus Error Logger with Interrupt Request

This block keeps the error record for one memory leaf and for the board's system-bus port. Memory error events arrive as strobes with a 2-bit kind code, a 40-bit failing address and a 16-bit syndrome. The block turns these events into sticky status flags, holds the address and syndrome of the most recent event, and sets a multiple-error flag when errors pile up. A syndrome is marked usable only while exactly one status flag is set. Bus error events are kept as four sticky flags. Software clears them with a single write strobe.

Two 17-bit interrupt control words hold an enable, an 8-bit priority and a 7-bit destination. One word serves memory errors and the other serves bus errors. Only some event kinds raise an interrupt. A qualifying event produces a one-cycle request pulse that carries the priority and destination of its source. If both sources want the request in the same cycle, the higher priority goes first and the other waits.

Top module: `err_logger`

## Requirements
- R1: After reset the leaf status, bus status and `irq_o` are zero. The memory interrupt word reads 0x13322 and the bus interrupt word reads 0x13422.
- R2: An accepted memory event sets one leaf status bit, chosen by `mem_kind_i`: 0 (partial-write uncorrectable) sets bit0, 1 (read uncorrectable) sets bit1, and 2 (read single-bit correctable) sets bit2. Kind 3 is ignored: status, address and syndrome are left unchanged and no interrupt is raised.
- R3: Leaf status bit3 (multiple error) is set when an accepted event arrives while any of bits 2:0 is already set.
- R4: Every accepted event captures its address and syndrome on the clock edge that samples it. `err_addr_hi_o` shows address bits 39:32 and `err_addr_lo_o` shows bits 31:0.
- R5: `synd_valid_o` is high exactly when one leaf status bit is set.
- R6: Leaf status bits are sticky until `lst_clr_i`, which clears all four. An event in the same cycle as the clear is recorded on the cleared state.
- R7: Bus status bits are sticky. Bit3 is a sender address error, bit2 a sender data error, bit1 an address error on another board's transfer, and bit0 a data error on another board's transfer. `bus_clr_i` clears all four, and bits raised in the same cycle are kept.
- R8: `cfg_wr_i` writes `cfg_wdata_i` to the memory word (`cfg_sel_i`=0) or to the bus word (`cfg_sel_i`=1). In each word, bit16 is the enable, bits 15:8 the priority and bits 6:0 the destination. Bit7 always reads 0.
- R9: A memory event of kind 0 or kind 2 raises an interrupt only while bit16 of the memory word is set. Kind 1 and kind 3 never raise one.
- R10: A bus event on bit3 raises an interrupt only while bit16 of the bus word is set. Bits 2:0 never raise one.
- R11: Each granted request drives `irq_o` high for one cycle, starting on the edge that samples the event. `irq_prio_o` and `irq_dest_o` carry the fields of the granted source. When both sources request together, the higher priority is granted first and memory wins a tie. The loser is granted on a later cycle. Repeat requests from a source whose request is still waiting merge into that one request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_evt_i | input | 1 | Memory error event strobe |
| mem_kind_i | input | 2 | Memory error kind code |
| mem_addr_i | input | 40 | Failing address |
| mem_synd_i | input | 16 | Syndrome of the failing access |
| lst_clr_i | input | 1 | Clear all leaf status bits |
| bus_evt_i | input | 4 | Bus error event bits |
| bus_clr_i | input | 1 | Clear all bus status bits |
| cfg_wr_i | input | 1 | Interrupt word write strobe |
| cfg_sel_i | input | 1 | 0 selects the memory word, 1 the bus word |
| cfg_wdata_i | input | 17 | Interrupt word write data |
| leaf_status_o | output | 4 | Leaf error status |
| synd_valid_o | output | 1 | Captured syndrome is usable |
| err_synd_o | output | 16 | Captured syndrome |
| err_addr_hi_o | output | 8 | Captured address bits 39:32 |
| err_addr_lo_o | output | 32 | Captured address bits 31:0 |
| bus_status_o | output | 4 | Bus error status |
| mem_icfg_o | output | 17 | Memory interrupt word |
| bus_icfg_o | output | 17 | Bus interrupt word |
| irq_o | output | 1 | Interrupt request pulse |
| irq_prio_o | output | 8 | Priority of the granted request |
| irq_dest_o | output | 7 | Destination of the granted request |

## Verification
The assertions assume three things about the inputs: they are quiet during reset, `mem_kind_i` is meaningful only while `mem_evt_i` is high, and strobes are sampled at clock edges. The check on interrupt fields also assumes a request reaches `irq_o` on the edge after the interrupt word last held its fields. The bench drives all inputs on the falling edge and drops every strobe after one cycle. It does not change an interrupt word while a request from that source is still waiting. This way every pulse matches a word value that was present on the edge before.

// File: rtl/err_log_pkg.sv
package err_log_pkg;
  localparam int PRIO_W   = 8;
  localparam int DEST_W   = 7;
  localparam int IC_W     = PRIO_W + DEST_W + 2;
  localparam int IC_EN    = IC_W - 1;
  localparam int IC_PLSB  = DEST_W + 1;
  localparam int IC_GAP   = DEST_W;
  localparam int ST_W     = 4;
  localparam int ST_MULT  = 3;
  localparam int BUS_W    = 4;
  localparam int BUS_SADR = 3;

  typedef enum logic [1:0] {
    EK_PWR_UNC = 2'd0,
    EK_RD_UNC  = 2'd1,
    EK_RD_SGL  = 2'd2,
    EK_RSVD    = 2'd3
  } err_kind_e;

  function automatic logic kind_irqs(err_kind_e k);
    return (k == EK_PWR_UNC) || (k == EK_RD_SGL);
  endfunction
endpackage

// File: rtl/leaf_err_log.sv
module leaf_err_log
  import err_log_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int SYND_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_i,
  input  err_kind_e         kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SYND_W-1:0] synd_i,
  input  logic              clr_i,
  output logic [ST_W-1:0]   status_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [SYND_W-1:0] synd_o,
  output logic              synd_valid_o,
  output logic              irq_req_o
);
  logic [ST_W-1:0] st_q, st_base, st_d;
  logic            acc;

  assign acc = evt_i && (kind_i != EK_RSVD);

  always_comb begin
    st_base = clr_i ? '0 : st_q;
    st_d    = st_base;
    if (acc) begin
      st_d[kind_i] = 1'b1;
      if (|st_base[ST_MULT-1:0]) st_d[ST_MULT] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= '0;
      addr_o <= '0;
      synd_o <= '0;
    end else begin
      st_q <= st_d;
      if (acc) begin
        addr_o <= addr_i;
        synd_o <= synd_i;
      end
    end
  end

  assign status_o     = st_q;
  assign synd_valid_o = ($countones(st_q) == 1);
  assign irq_req_o    = evt_i && kind_irqs(kind_i);
endmodule

// File: rtl/bus_err_log.sv
module bus_err_log
  import err_log_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BUS_W-1:0] evt_i,
  input  logic             clr_i,
  output logic [BUS_W-1:0] status_o,
  output logic             irq_req_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_o <= '0;
    else         status_o <= (clr_i ? '0 : status_o) | evt_i;
  end

  // only the sender-side address error interrupts
  assign irq_req_o = evt_i[BUS_SADR];
endmodule

// File: rtl/irq_cfg_reg.sv
module irq_cfg_reg
  import err_log_pkg::*;
#(
  parameter logic [IC_W-1:0] RST_VAL = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [IC_W-1:0] wdata_i,
  output logic [IC_W-1:0] q_o
);
  localparam logic [IC_W-1:0] KEEP = ~(IC_W'(1) << IC_GAP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST_VAL & KEEP;
    else if (wr_i) q_o <= wdata_i & KEEP;
  end
endmodule

// File: rtl/irq_arb.sv
module irq_arb
  import err_log_pkg::*;
#(
  parameter int NSRC = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NSRC-1:0]              req_i,
  input  logic [NSRC-1:0][PRIO_W-1:0]  prio_i,
  input  logic [NSRC-1:0][DEST_W-1:0]  dest_i,
  output logic                         irq_o,
  output logic [PRIO_W-1:0]            prio_o,
  output logic [DEST_W-1:0]            dest_o
);
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC-1:0]   pend_q, want, grant;
  logic [IDX_W-1:0]  win;
  logic              any;

  assign want = pend_q | req_i;

  // lowest index wins ties: only a strictly higher priority displaces it
  always_comb begin
    win = '0;
    any = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (want[i] && (!any || prio_i[i] > prio_i[win])) begin
        win = IDX_W'(i);
        any = 1'b1;
      end
    end
    grant = '0;
    if (any) grant[win] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      irq_o  <= 1'b0;
      prio_o <= '0;
      dest_o <= '0;
    end else begin
      pend_q <= want & ~grant;
      irq_o  <= any;
      if (any) begin
        prio_o <= prio_i[win];
        dest_o <= dest_i[win];
      end
    end
  end
endmodule

// File: rtl/err_logger.sv
module err_logger
  import err_log_pkg::*;
#(
  parameter int              ADDR_W     = 40,
  parameter int              SYND_W     = 16,
  parameter logic [IC_W-1:0] MEM_IC_RST = 17'h13322,
  parameter logic [IC_W-1:0] BUS_IC_RST = 17'h13422
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mem_evt_i,
  input  logic [1:0]        mem_kind_i,
  input  logic [ADDR_W-1:0] mem_addr_i,
  input  logic [SYND_W-1:0] mem_synd_i,
  input  logic              lst_clr_i,
  input  logic [BUS_W-1:0]  bus_evt_i,
  input  logic              bus_clr_i,
  input  logic              cfg_wr_i,
  input  logic              cfg_sel_i,
  input  logic [IC_W-1:0]   cfg_wdata_i,
  output logic [ST_W-1:0]   leaf_status_o,
  output logic              synd_valid_o,
  output logic [SYND_W-1:0] err_synd_o,
  output logic [ADDR_W-33:0] err_addr_hi_o,
  output logic [31:0]       err_addr_lo_o,
  output logic [BUS_W-1:0]  bus_status_o,
  output logic [IC_W-1:0]   mem_icfg_o,
  output logic [IC_W-1:0]   bus_icfg_o,
  output logic              irq_o,
  output logic [PRIO_W-1:0] irq_prio_o,
  output logic [DEST_W-1:0] irq_dest_o
);
  localparam int NSRC = 2;
  localparam logic [NSRC-1:0][IC_W-1:0] IC_RST = {BUS_IC_RST, MEM_IC_RST};

  logic [ADDR_W-1:0]             addr_cap;
  logic                          mem_req, bus_req;
  logic [NSRC-1:0]               raw_req, req;
  logic [NSRC-1:0][IC_W-1:0]     icfg;
  logic [NSRC-1:0][PRIO_W-1:0]   prio;
  logic [NSRC-1:0][DEST_W-1:0]   dest;

  leaf_err_log #(.ADDR_W(ADDR_W), .SYND_W(SYND_W)) u_leaf (
    .clk_i, .rst_ni,
    .evt_i        (mem_evt_i),
    .kind_i       (err_kind_e'(mem_kind_i)),
    .addr_i       (mem_addr_i),
    .synd_i       (mem_synd_i),
    .clr_i        (lst_clr_i),
    .status_o     (leaf_status_o),
    .addr_o       (addr_cap),
    .synd_o       (err_synd_o),
    .synd_valid_o (synd_valid_o),
    .irq_req_o    (mem_req)
  );

  bus_err_log u_bus (
    .clk_i, .rst_ni,
    .evt_i     (bus_evt_i),
    .clr_i     (bus_clr_i),
    .status_o  (bus_status_o),
    .irq_req_o (bus_req)
  );

  assign raw_req = {bus_req, mem_req};

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    irq_cfg_reg #(.RST_VAL(IC_RST[s])) u_icfg (
      .clk_i, .rst_ni,
      .wr_i    (cfg_wr_i && (cfg_sel_i == s[0])),
      .wdata_i (cfg_wdata_i),
      .q_o     (icfg[s])
    );
    assign req[s]  = raw_req[s] && icfg[s][IC_EN];
    assign prio[s] = icfg[s][IC_EN-1:IC_PLSB];
    assign dest[s] = icfg[s][DEST_W-1:0];
  end

  irq_arb #(.NSRC(NSRC)) u_arb (
    .clk_i, .rst_ni,
    .req_i  (req),
    .prio_i (prio),
    .dest_i (dest),
    .irq_o  (irq_o),
    .prio_o (irq_prio_o),
    .dest_o (irq_dest_o)
  );

  assign err_addr_hi_o = addr_cap[ADDR_W-1:32];
  assign err_addr_lo_o = addr_cap[31:0];
  assign mem_icfg_o    = icfg[0];
  assign bus_icfg_o    = icfg[1];
endmodule

// File: rtl/err_logger_chk.sv
module err_logger_chk #(
  parameter int ADDR_W = 40,
  parameter int SYND_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_evt_i,
  input logic [1:0]        mem_kind_i,
  input logic [ADDR_W-1:0] mem_addr_i,
  input logic              lst_clr_i,
  input logic [3:0]        bus_evt_i,
  input logic              bus_clr_i,
  input logic [3:0]        leaf_status_o,
  input logic              synd_valid_o,
  input logic [ADDR_W-33:0] err_addr_hi_o,
  input logic [31:0]       err_addr_lo_o,
  input logic [3:0]        bus_status_o,
  input logic [16:0]       mem_icfg_o,
  input logic [16:0]       bus_icfg_o,
  input logic              irq_o,
  input logic [7:0]        irq_prio_o,
  input logic [6:0]        irq_dest_o
);
  AST_RSVD_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(mem_evt_i && mem_kind_i == 2'd3 && !lst_clr_i) |-> $stable(leaf_status_o) && $stable(err_addr_lo_o)); // R2
  AST_MULT_NEEDS_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(leaf_status_o[3]) |-> $past(mem_evt_i)); // R3
  AST_ADDR_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(mem_evt_i && mem_kind_i != 2'd3) |-> {err_addr_hi_o, err_addr_lo_o} == $past(mem_addr_i)); // R4
  AST_MULT_NO_SYND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    leaf_status_o[3] |-> !synd_valid_o); // R5
  AST_SYND_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    synd_valid_o |-> $countones(leaf_status_o) == 1); // R5
  AST_LEAF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(lst_clr_i) |-> (leaf_status_o & $past(leaf_status_o)) == $past(leaf_status_o)); // R6
  AST_BUS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(bus_clr_i) |-> bus_status_o == $past(bus_evt_i)); // R7
  AST_GAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_icfg_o[7] && !bus_icfg_o[7]); // R8
  AST_IRQ_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ($past(mem_icfg_o[16]) && irq_prio_o == $past(mem_icfg_o[15:8]) && irq_dest_o == $past(mem_icfg_o[6:0]))
           || ($past(bus_icfg_o[16]) && irq_prio_o == $past(bus_icfg_o[15:8]) && irq_dest_o == $past(bus_icfg_o[6:0]))); // R11
endmodule

bind err_logger err_logger_chk #(.ADDR_W(ADDR_W), .SYND_W(SYND_W)) u_chk (
  .clk_i, .rst_ni, .mem_evt_i, .mem_kind_i, .mem_addr_i, .lst_clr_i,
  .bus_evt_i, .bus_clr_i, .leaf_status_o, .synd_valid_o, .err_addr_hi_o,
  .err_addr_lo_o, .bus_status_o, .mem_icfg_o, .bus_icfg_o, .irq_o,
  .irq_prio_o, .irq_dest_o
);

// File: tb/err_logger_test.sv
module err_logger_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mem_evt_i = 1'b0;
  logic [1:0]  mem_kind_i = '0;
  logic [39:0] mem_addr_i = '0;
  logic [15:0] mem_synd_i = '0;
  logic        lst_clr_i = 1'b0;
  logic [3:0]  bus_evt_i = '0;
  logic        bus_clr_i = 1'b0;
  logic        cfg_wr_i = 1'b0;
  logic        cfg_sel_i = 1'b0;
  logic [16:0] cfg_wdata_i = '0;
  logic [3:0]  leaf_status_o;
  logic        synd_valid_o;
  logic [15:0] err_synd_o;
  logic [7:0]  err_addr_hi_o;
  logic [31:0] err_addr_lo_o;
  logic [3:0]  bus_status_o;
  logic [16:0] mem_icfg_o, bus_icfg_o;
  logic        irq_o;
  logic [7:0]  irq_prio_o;
  logic [6:0]  irq_dest_o;

  int n_chk = 0;
  int n_fail = 0;

  // expected state
  logic [3:0]  m_st = '0;
  logic [39:0] m_addr = '0;
  logic [15:0] m_syn = '0;
  logic [3:0]  m_bus = '0;
  logic [16:0] m_mc = 17'h13322;
  logic [16:0] m_bc = 17'h13422;
  logic        m_pm = 1'b0, m_pb = 1'b0, m_irq = 1'b0;
  logic [7:0]  m_prio = '0;
  logic [6:0]  m_dest = '0;

  err_logger uut (.*);

  always #4 clk_i = ~clk_i;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one clock with the inputs as currently driven; model advances, outputs compared
  task automatic cycle(string tag);
    logic [3:0] st;
    logic rm, rb, gm;
    st = lst_clr_i ? 4'd0 : m_st;
    if (mem_evt_i && mem_kind_i != 2'd3) begin
      if (|st[2:0]) st[3] = 1'b1;
      st[mem_kind_i] = 1'b1;
      m_addr = mem_addr_i;
      m_syn  = mem_synd_i;
    end
    rm = m_pm | (mem_evt_i && (mem_kind_i == 2'd0 || mem_kind_i == 2'd2) && m_mc[16]);
    rb = m_pb | (bus_evt_i[3] && m_bc[16]);
    gm = rm && (!rb || m_mc[15:8] >= m_bc[15:8]);
    m_irq = rm | rb;
    if (gm)      begin m_prio = m_mc[15:8]; m_dest = m_mc[6:0]; end
    else if (rb) begin m_prio = m_bc[15:8]; m_dest = m_bc[6:0]; end
    m_pm = rm & ~gm;
    m_pb = rb & gm;
    m_bus = (bus_clr_i ? 4'd0 : m_bus) | bus_evt_i;
    if (cfg_wr_i) begin
      if (cfg_sel_i) m_bc = cfg_wdata_i & ~17'h80;
      else           m_mc = cfg_wdata_i & ~17'h80;
    end
    m_st = st;
    @(posedge clk_i);
    @(negedge clk_i);
    mem_evt_i = 1'b0; lst_clr_i = 1'b0; bus_evt_i = '0; bus_clr_i = 1'b0; cfg_wr_i = 1'b0;
    chk(tag, "leaf_status", 64'(leaf_status_o), 64'(m_st));
    chk(tag, "synd_valid", 64'(synd_valid_o), 64'($countones(m_st) == 1));
    chk(tag, "addr", {24'd0, err_addr_hi_o, err_addr_lo_o}, 64'(m_addr));
    chk(tag, "synd", 64'(err_synd_o), 64'(m_syn));
    chk(tag, "bus_status", 64'(bus_status_o), 64'(m_bus));
    chk(tag, "mem_icfg", 64'(mem_icfg_o), 64'(m_mc));
    chk(tag, "bus_icfg", 64'(bus_icfg_o), 64'(m_bc));
    chk(tag, "irq", 64'(irq_o), 64'(m_irq));
    if (m_irq) chk(tag, "irq_fields", {49'd0, irq_prio_o, irq_dest_o}, {49'd0, m_prio, m_dest});
  endtask

  task automatic mem_ev(logic [1:0] k, logic [39:0] a, logic [15:0] s);
    mem_evt_i = 1'b1; mem_kind_i = k; mem_addr_i = a; mem_synd_i = s;
  endtask

  task automatic wr_cfg(logic sel, logic [16:0] d, string tag);
    cfg_wr_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = d;
    cycle(tag);
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) cycle(tag);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    chk("R1", "leaf_status", 64'(leaf_status_o), 64'd0);
    chk("R1", "bus_status", 64'(bus_status_o), 64'd0);
    chk("R1", "mem_icfg", 64'(mem_icfg_o), 64'h13322);
    chk("R1", "bus_icfg", 64'(bus_icfg_o), 64'h13422);
    chk("R1", "irq", 64'(irq_o), 64'd0);

    // R2: each kind alone on a clean status
    for (int k = 0; k < 4; k++) begin
      lst_clr_i = 1'b1; cycle("R2");
      mem_ev(2'(k), 40'hA5_0000_0000 | 40'(k * 17), 16'(16'h1000 + k));
      cycle("R2");
      idle("R2", 2);
    end

    // R3 / R5: every ordered pair of kinds
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        lst_clr_i = 1'b1; cycle("R3");
        mem_ev(2'(a), 40'(a * 64'h1_0000_0001), 16'(a));
        cycle("R5");
        mem_ev(2'(b), 40'(b * 64'h3_0000_0005 + 7), 16'(b + 16'h100));
        cycle("R3");
        idle("R5", 2);
      end
    end

    // R4: walking-one address and syndrome
    for (int i = 0; i < 40; i++) begin
      mem_ev(2'd1, 40'd1 << i, 16'(i * 16'h0409));
      cycle("R4");
    end

    // R6: clear with a same-cycle event
    for (int k = 0; k < 4; k++) begin
      mem_ev(2'd1, 40'h11, 16'h22); cycle("R6");
      mem_ev(2'd2, 40'h33, 16'h44); cycle("R6");
      lst_clr_i = 1'b1; mem_ev(2'(k), 40'(64'hFF_0000_0000 + k), 16'(k)); cycle("R6");
      idle("R6", 2);
    end
    lst_clr_i = 1'b1; cycle("R6");

    // R7: every bus pattern, then clear with the complement raised at once
    for (int v = 0; v < 16; v++) begin
      bus_evt_i = 4'(v); cycle("R7");
      bus_clr_i = 1'b1; bus_evt_i = ~4'(v); cycle("R7");
      bus_clr_i = 1'b1; cycle("R7");
      idle("R7", 2);
    end

    // R8: interrupt word writes including bit7
    wr_cfg(1'b0, 17'h1FFFF, "R8");
    wr_cfg(1'b1, 17'h00000, "R8");
    wr_cfg(1'b0, 17'h0ABCD, "R8");
    wr_cfg(1'b1, 17'h15A80, "R8");
    wr_cfg(1'b1, 17'h00000, "R8");

    // R9: memory interrupt per kind, enable off then on
    for (int en = 0; en < 2; en++) begin
      wr_cfg(1'b0, {1'(en), 8'h40, 1'b0, 7'h15}, "R9");
      for (int k = 0; k < 4; k++) begin
        mem_ev(2'(k), 40'(k), 16'(k)); cycle("R9");
        idle("R9", 1);
      end
    end

    // R10: bus interrupt per bit, enable off then on
    wr_cfg(1'b0, 17'h0, "R10");
    for (int en = 0; en < 2; en++) begin
      wr_cfg(1'b1, {1'(en), 8'h21, 1'b0, 7'h6A}, "R10");
      for (int b = 0; b < 4; b++) begin
        bus_evt_i = 4'd1 << b; cycle("R10");
        idle("R10", 1);
      end
    end

    // R11: simultaneous requests across priority orderings, then merging
    for (int p = 0; p < 3; p++) begin
      wr_cfg(1'b0, {1'b1, 8'(8'h50 + p - 1), 1'b0, 7'h0C}, "R11");
      wr_cfg(1'b1, {1'b1, 8'h50, 1'b0, 7'h73}, "R11");
      mem_ev(2'd2, 40'h5, 16'h5); bus_evt_i = 4'h8; cycle("R11");
      idle("R11", 3);
    end
    wr_cfg(1'b0, {1'b1, 8'h10, 1'b0, 7'h01}, "R11");
    mem_ev(2'd0, 40'h6, 16'h6); bus_evt_i = 4'h8; cycle("R11");
    mem_ev(2'd2, 40'h7, 16'h7); bus_evt_i = 4'h8; cycle("R11");
    mem_ev(2'd0, 40'h8, 16'h8); cycle("R11");
    idle("R11", 3);

    summary();
    $finish;
  end
endmodule